// File: doc/BRIEF.md
# DRAM Controller Statistics Counter Bank

This block sits beside a DRAM scheduler and keeps its performance statistics in hardware. The scheduler sends single-cycle event strobes for a new request (with the target bank), a read issue, a write issue and a refresh. It also sends one strobe per reason why a queue head could not issue this cycle, and per-cycle cycle amounts for head-of-queue waiting, input-queue occupancy and bank-queue backlog. Every statistic is a saturating counter of `CNT_W` bits, and a separate access counter exists for every bank of the channel.

When several stall reasons are raised in the same cycle, the cycle is charged to exactly one of them, the one with the highest priority. As a result the eight reason counters split the head-wait figure without counting a cycle twice. Software reads any counter through an index port with one cycle of latency. It reads the derived total delay the same way and divides by the request count itself. A synchronous clear zeroes everything.

Top module: `mc_stat_counters`

## Requirements
- R1: After reset every index reads zero and `statsValid` is low.
- R2: A `reqStrobe` adds one to the request counter (index 0) and one to the counter of bank `reqBank`. Bank b is read at index 16+b, and the bank count is `BANKS_PER_RANK*RANKS_PER_DIMM*DIMMS_PER_CHAN`.
- R3: A `refStrobe` adds one to the refresh counter (index 3) and never changes the request counter. `statsValid` is high exactly when the request count or the refresh count is nonzero.
- R4: `rdStrobe` adds one to index 1, and `wrStrobe` adds one to index 2.
- R5: Every cycle, `waitAmt`, `inqAmt` and `bankqAmt` are added to index 4, index 5 and index 6 respectively.
- R6: `stallVec` bit k maps to the counter at index 7+k. Bit 0 has the highest priority and bit 7 the lowest. In a cycle only the lowest-numbered set bit is counted. The bit order is: bank busy, random busy, anti-starvation, arbitration, bus busy, four-activate window, read-to-write turnaround, rank-to-rank read turnaround.
- R7: When the arbitration reason (bit 3) is the one counted, its counter grows by `arbAmt`. Every other reason counter grows by one.
- R8: Index 15 reads the sum of indices 4, 5 and 6, saturated to all ones.
- R9: Every counter stops at all ones instead of wrapping.
- R10: `clear` zeroes all counters, including the per-bank counters. If an increment arrives in the same cycle as `clear`, the clear takes precedence.
- R11: `rdData` shows, one cycle after `rdIdx` is presented, the value the selected counter held when it was sampled. An index beyond the last bank reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all counters |
| reqStrobe | input | 1 | New request accepted |
| reqBank | input | BANK_W | Bank index of the request |
| rdStrobe | input | 1 | Read issued |
| wrStrobe | input | 1 | Write issued |
| refStrobe | input | 1 | Refresh issued |
| stallVec | input | 8 | Stall reasons raised this cycle, bit 0 highest priority |
| arbAmt | input | AMT_W | Cycles charged to arbitration when it wins |
| waitAmt | input | AMT_W | Head-of-queue wait cycles this cycle |
| inqAmt | input | AMT_W | Input-queue occupancy this cycle |
| bankqAmt | input | AMT_W | Bank-queue backlog this cycle |
| rdIdx | input | IDX_W | Counter select for the read port |
| rdData | output | CNT_W | Registered counter value |
| statsValid | output | 1 | Any request or refresh recorded |

## Verification
Two of the block's functions can meet in a single cycle. First, a clear can coincide with a request and read strobe. The bench drives both in the same cycle and then expects the request counter and the bank counter to read zero. Second, several stall reasons can be raised together. The bench drives all eight, then selected subsets including the arbitration bit with a cycle amount, and judges the result by reading all eight reason counters. Only the highest-priority reason of each cycle may have moved.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int NUM_STALL  = 8;
  localparam int NUM_SCALAR = 15;
  localparam int IDX_TOTAL  = 15;
  localparam int BANK_BASE  = 16;
  localparam int C_REQ   = 0;
  localparam int C_RD    = 1;
  localparam int C_WR    = 2;
  localparam int C_REF   = 3;
  localparam int C_WAIT  = 4;
  localparam int C_INQ   = 5;
  localparam int C_BANKQ = 6;
  localparam int C_STALL = 7;
  localparam int STALL_ARB = 3;

  typedef struct packed {
    logic                  clr;
    logic [NUM_SCALAR-1:0] en;
    logic                  bankHit;
  } evt_t;
endpackage

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clear,
  input  logic                 reqStrobe,
  input  logic                 rdStrobe,
  input  logic                 wrStrobe,
  input  logic                 refStrobe,
  input  logic [NUM_STALL-1:0] stallVec,
  output evt_t                 evt
);
  logic [NUM_STALL-1:0] stallWin;

  // Fixed priority: lowest set bit takes the cycle.
  always_comb begin
    logic found;
    found    = 1'b0;
    stallWin = '0;
    for (int k = 0; k < NUM_STALL; k++) begin
      if (stallVec[k] && !found) begin
        stallWin[k] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    evt.clr                           = clear;
    evt.en                            = '0;
    evt.en[C_REQ]                     = reqStrobe;
    evt.en[C_RD]                      = rdStrobe;
    evt.en[C_WR]                      = wrStrobe;
    evt.en[C_REF]                     = refStrobe;
    evt.en[C_WAIT]                    = 1'b1;
    evt.en[C_INQ]                     = 1'b1;
    evt.en[C_BANKQ]                   = 1'b1;
    evt.en[C_STALL +: NUM_STALL]      = stallWin;
    evt.bankHit                       = reqStrobe;
  end

  // R6: at most one reason charged, and the top one always wins
  a_r6_single_reason: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(evt.en[C_STALL +: NUM_STALL]));
  a_r6_top_wins: assert property (@(posedge clk) disable iff (!rstN)
    stallVec[0] |-> evt.en[C_STALL]);
  // R3: refresh alone never reaches the request counter
  a_r3_ref_not_req: assert property (@(posedge clk) disable iff (!rstN)
    (refStrobe && !reqStrobe) |-> !evt.en[C_REQ]);
endmodule

// File: rtl/mcs_datapath.sv
module mcs_datapath
  import mcs_pkg::*;
#(
  parameter int CNT_W       = 64,
  parameter int AMT_W       = 8,
  parameter int TOTAL_BANKS = 8,
  parameter int BANK_W      = 3,
  parameter int IDX_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  evt_t              evt,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [AMT_W-1:0]  arbAmt,
  input  logic [AMT_W-1:0]  waitAmt,
  input  logic [AMT_W-1:0]  inqAmt,
  input  logic [AMT_W-1:0]  bankqAmt,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [CNT_W-1:0]  rdData,
  output logic              statsValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt     [NUM_SCALAR];
  logic [CNT_W-1:0] bankCnt [TOTAL_BANKS];
  logic [CNT_W-1:0] totalSat;
  logic [CNT_W-1:0] readVal;

  for (genvar i = 0; i < NUM_SCALAR; i++) begin : g_scalar
    logic [CNT_W-1:0] step;
    logic [CNT_W:0]   nextSum;
    if (i == C_WAIT) begin : g_w
      assign step = CNT_W'(waitAmt);
    end else if (i == C_INQ) begin : g_i
      assign step = CNT_W'(inqAmt);
    end else if (i == C_BANKQ) begin : g_b
      assign step = CNT_W'(bankqAmt);
    end else if (i == C_STALL + STALL_ARB) begin : g_a
      assign step = CNT_W'(arbAmt);
    end else begin : g_one
      assign step = CNT_W'(1);
    end
    assign nextSum = {1'b0, cnt[i]} + {1'b0, step};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           cnt[i] <= '0;
      else if (evt.clr)    cnt[i] <= '0;
      else if (evt.en[i])  cnt[i] <= nextSum[CNT_W] ? CNT_MAX : nextSum[CNT_W-1:0];
    end

    // R9: a full counter holds unless cleared
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[i] == CNT_MAX && !evt.clr) |=> cnt[i] == CNT_MAX);
  end

  for (genvar b = 0; b < TOTAL_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = evt.bankHit && (reqBank == BANK_W'(b));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      bankCnt[b] <= '0;
      else if (evt.clr) bankCnt[b] <= '0;
      else if (hit && bankCnt[b] != CNT_MAX) bankCnt[b] <= bankCnt[b] + 1'b1;
    end
  end

  always_comb begin
    logic [CNT_W+1:0] sum3;
    sum3 = {2'b00, cnt[C_WAIT]} + {2'b00, cnt[C_INQ]} + {2'b00, cnt[C_BANKQ]};
    totalSat = (|sum3[CNT_W+1:CNT_W]) ? CNT_MAX : sum3[CNT_W-1:0];
  end

  always_comb begin
    readVal = '0;
    for (int i = 0; i < NUM_SCALAR; i++)
      if (rdIdx == IDX_W'(i)) readVal = cnt[i];
    if (rdIdx == IDX_W'(IDX_TOTAL)) readVal = totalSat;
    for (int b = 0; b < TOTAL_BANKS; b++)
      if (rdIdx == IDX_W'(BANK_BASE + b)) readVal = bankCnt[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= readVal;
  end

  assign statsValid = (|cnt[C_REQ]) || (|cnt[C_REF]);

  // R10: clear wins over any same-cycle increment
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    evt.clr |=> (cnt[C_REQ] == '0 && bankCnt[0] == '0));
  // R2: an accepted request moves the request counter by exactly one
  a_r2_req_step: assert property (@(posedge clk) disable iff (!rstN)
    (evt.en[C_REQ] && !evt.clr && cnt[C_REQ] != CNT_MAX) |=> cnt[C_REQ] == $past(cnt[C_REQ]) + 1'b1);
  // R11: index 0 is returned one cycle later with its sampled value
  a_r11_read_lat: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == '0) |=> rdData == $past(cnt[C_REQ]));
endmodule

// File: rtl/mc_stat_counters.sv
module mc_stat_counters
  import mcs_pkg::*;
#(
  parameter int BANKS_PER_RANK = 4,
  parameter int RANKS_PER_DIMM = 2,
  parameter int DIMMS_PER_CHAN = 1,
  parameter int CNT_W          = 64,
  parameter int AMT_W          = 8,
  localparam int TOTAL_BANKS   = BANKS_PER_RANK * RANKS_PER_DIMM * DIMMS_PER_CHAN,
  localparam int BANK_W        = (TOTAL_BANKS > 1) ? $clog2(TOTAL_BANKS) : 1,
  localparam int IDX_W         = $clog2(BANK_BASE + TOTAL_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clear,
  input  logic                 reqStrobe,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic                 rdStrobe,
  input  logic                 wrStrobe,
  input  logic                 refStrobe,
  input  logic [NUM_STALL-1:0] stallVec,
  input  logic [AMT_W-1:0]     arbAmt,
  input  logic [AMT_W-1:0]     waitAmt,
  input  logic [AMT_W-1:0]     inqAmt,
  input  logic [AMT_W-1:0]     bankqAmt,
  input  logic [IDX_W-1:0]     rdIdx,
  output logic [CNT_W-1:0]     rdData,
  output logic                 statsValid
);
  evt_t evt;

  mcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .reqStrobe(reqStrobe),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .refStrobe(refStrobe),
    .stallVec(stallVec), .evt(evt)
  );

  mcs_datapath #(
    .CNT_W(CNT_W), .AMT_W(AMT_W), .TOTAL_BANKS(TOTAL_BANKS),
    .BANK_W(BANK_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .evt(evt), .reqBank(reqBank), .arbAmt(arbAmt),
    .waitAmt(waitAmt), .inqAmt(inqAmt), .bankqAmt(bankqAmt),
    .rdIdx(rdIdx), .rdData(rdData), .statsValid(statsValid)
  );
endmodule

// File: tb/mc_stat_counters_bench.sv
`timescale 1ns/1ps
module mc_stat_counters_bench;
  localparam int CW = 16;
  localparam int NB = 8;
  localparam logic [63:0] MAXV = 64'hFFFF;

  logic clk = 1'b0, rstN = 1'b0, clear = 1'b0;
  logic reqStrobe = 0, rdStrobe = 0, wrStrobe = 0, refStrobe = 0;
  logic [2:0] reqBank = '0;
  logic [7:0] stallVec = '0, arbAmt = '0, waitAmt = '0, inqAmt = '0, bankqAmt = '0;
  logic [4:0] rdIdx = '0;
  logic [CW-1:0] rdData;
  logic statsValid;

  int checks = 0, errors = 0;
  logic issue = 1'b0;
  logic [63:0] mCnt [15];
  logic [63:0] mBank [NB];
  int idxQ[$];
  logic [63:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  mc_stat_counters #(.CNT_W(CW)) u_mc_stat_counters (
    .clk(clk), .rstN(rstN), .clear(clear), .reqStrobe(reqStrobe), .reqBank(reqBank),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .refStrobe(refStrobe), .stallVec(stallVec),
    .arbAmt(arbAmt), .waitAmt(waitAmt), .inqAmt(inqAmt), .bankqAmt(bankqAmt),
    .rdIdx(rdIdx), .rdData(rdData), .statsValid(statsValid)
  );

  function automatic logic [63:0] sat(input logic [63:0] a, input logic [63:0] b);
    return (a + b > MAXV) ? MAXV : a + b;
  endfunction

  function automatic logic [63:0] expectOf(input int idx);
    if (idx < 15) return mCnt[idx];
    if (idx == 15) return sat(sat(mCnt[4], mCnt[5]), mCnt[6]);
    if (idx < 16 + NB) return mBank[idx-16];
    return 64'd0;
  endfunction

  // Apply current inputs for one edge and update the model.
  task automatic pulse();
    if (clear) begin
      for (int i = 0; i < 15; i++) mCnt[i] = 0;
      for (int b = 0; b < NB; b++) mBank[b] = 0;
    end else begin
      if (reqStrobe) begin mCnt[0] = sat(mCnt[0], 1); mBank[reqBank] = sat(mBank[reqBank], 1); end
      if (rdStrobe)  mCnt[1] = sat(mCnt[1], 1);
      if (wrStrobe)  mCnt[2] = sat(mCnt[2], 1);
      if (refStrobe) mCnt[3] = sat(mCnt[3], 1);
      mCnt[4] = sat(mCnt[4], 64'(waitAmt));
      mCnt[5] = sat(mCnt[5], 64'(inqAmt));
      mCnt[6] = sat(mCnt[6], 64'(bankqAmt));
      for (int k = 0; k < 8; k++) begin
        if (stallVec[k]) begin
          mCnt[7+k] = sat(mCnt[7+k], (k == 3) ? 64'(arbAmt) : 64'd1);
          break;
        end
      end
    end
    @(negedge clk);
    clear = 0; reqStrobe = 0; rdStrobe = 0; wrStrobe = 0; refStrobe = 0;
    stallVec = '0; arbAmt = '0; waitAmt = '0; inqAmt = '0; bankqAmt = '0;
  endtask

  task automatic readChk(input int idx, input string tag);
    rdIdx = 5'(idx);
    idxQ.push_back(idx);
    expQ.push_back(expectOf(idx));
    tagQ.push_back(tag);
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic validChk(input logic exp, input string tag);
    checks++;
    if (statsValid !== exp) begin
      errors++;
      $display("FAIL %s statsValid actual %0b expected %0b", tag, statsValid, exp);
    end
  endtask

  // Scoreboard monitor
  always @(posedge clk) begin
    logic iss;
    iss = issue;
    #1;
    if (iss && idxQ.size() > 0) begin
      int idx;
      logic [63:0] e;
      string t;
      idx = idxQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
      checks++;
      if (64'(rdData) !== e) begin
        errors++;
        $display("FAIL %s index %0d actual %0h expected %0h", t, idx, rdData, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) mCnt[i] = 0;
    for (int b = 0; b < NB; b++) mBank[b] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 24; i++) readChk(i, "R1");
    validChk(1'b0, "R1");

    // R2 and R4: requests to first, last and a middle bank
    reqStrobe = 1; reqBank = 0; rdStrobe = 1; pulse();
    reqStrobe = 1; reqBank = 7; wrStrobe = 1; pulse();
    reqStrobe = 1; reqBank = 3; pulse();
    reqStrobe = 1; reqBank = 3; rdStrobe = 1; pulse();
    readChk(0, "R2"); readChk(16, "R2"); readChk(19, "R2"); readChk(23, "R2");
    readChk(1, "R4"); readChk(2, "R4");
    validChk(1'b1, "R3");

    // R3 refresh alone
    clear = 1; pulse();
    validChk(1'b0, "R10");
    refStrobe = 1; pulse();
    validChk(1'b1, "R3");
    readChk(0, "R3"); readChk(3, "R3");

    // R5 and R8 amounts
    waitAmt = 5; inqAmt = 3; bankqAmt = 2; pulse();
    waitAmt = 7; inqAmt = 1; bankqAmt = 0; pulse();
    readChk(4, "R5"); readChk(5, "R5"); readChk(6, "R5"); readChk(15, "R8");

    // R6 and R7 stall priority
    stallVec = 8'hFF; arbAmt = 9; pulse();
    stallVec = 8'hC0; pulse();
    stallVec = 8'h88; arbAmt = 4; pulse();
    stallVec = 8'h80; pulse();
    stallVec = 8'h14; pulse();
    for (int k = 7; k < 15; k++) readChk(k, (k == 10) ? "R7" : "R6");

    // R10 clear against a same-cycle request
    reqStrobe = 1; reqBank = 0; rdStrobe = 1; pulse();
    clear = 1; reqStrobe = 1; reqBank = 0; rdStrobe = 1; pulse();
    readChk(0, "R10"); readChk(16, "R10"); readChk(1, "R10");

    // R11 out-of-range index and back-to-back reads
    reqStrobe = 1; reqBank = 5; pulse();
    readChk(31, "R11"); readChk(0, "R11"); readChk(21, "R11"); readChk(24, "R11");

    // R9 saturation
    for (int n = 0; n < 260; n++) begin waitAmt = 8'hFF; pulse(); end
    readChk(4, "R9"); readChk(15, "R9");
    waitAmt = 8'h10; pulse();
    readChk(4, "R9");

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule